// File: doc/BRIEF.md
# Byte-Lane Memory From 1-bit Cells

This block is an 8192-bit memory, 16 bits wide. It is built only from 1-bit storage cells, each 64 words deep, and uses 128 of them. The cells form 8 banks of 16 cells. Each bank holds 64 halfwords, so the memory gives 1024 bytes at byte addresses 0x000 to 0x3FF, at the bottom of the byte address space.

A request has these inputs:
- a byte address;
- an enable that stays high for the whole access;
- a write strobe;
- a size select, either byte or halfword;
- a 16-bit write-data port.

A 3-to-8 decoder picks the bank. Lane logic enables the low half of the bank's cells, the high half, or both. A steering stage returns the addressed byte or halfword on a registered 16-bit read-data port.

Addresses with any bit above bit 9 set select no cell. A halfword access at an odd address is refused and raises an error flag.

Top module: `bytelane_mem`

## Requirements
- R1: Byte address A (A < 0x400) maps to bank A[9:7], cell row A[6:1] and lane A[0]. A halfword at even address A holds byte A on bits 7:0 and byte A+1 on bits 15:8. Every location written can be read back unchanged.
- R2: A byte write (req_half=0) with address A stores wdata[7:0] into byte A only. Its partner byte A^1 keeps its value.
- R3: A byte read of address A returns byte A on rdata[7:0], and rdata[15:8] is zero.
- R4: A halfword write (req_half=1) at an even address stores wdata[7:0] at A and wdata[15:8] at A+1. A halfword read at an even address returns both bytes in that order.
- R5: A halfword access at an odd address sets align_err in the following cycle. It writes nothing. If it is a read, it loads zero into rdata.
- R6: An address with any bit above bit 9 set selects no cell. A write to it changes no byte. A read from it loads zero into rdata.
- R7: rdata is loaded only on a clock edge where req_en=1 and req_wr=0. It holds its value in every other cycle.
- R8: A write takes effect only on a clock edge where both req_en and req_wr are 1.
- R9: After reset, rdata is zero and align_err is zero. align_err is low in any cycle that follows a cycle with no misaligned halfword access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read capture on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| req_en | input | 1 | Access enable, high for the whole access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword access, 0 = byte access |
| req_addr | input | 16 | Byte address |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rdata | output | 16 | Registered read data |
| align_err | output | 1 | High the cycle after a misaligned halfword access |

## Verification
The bench aims at the following corner cases, and at what a design that got each one wrong would do:

- **Byte lane steering.** A swapped lane would return the partner byte. An unmasked write enable would corrupt the partner byte. The bench catches both by reading back both bytes after every byte write.
- **Out-of-range writes.** A decoder that ignores the upper address bits would alias such a write onto the low 1 KiB. The bench writes at offsets of 0x400 and higher, then rereads the aliased byte.
- **Misaligned halfwords.** A design that drops the alignment check would write two bytes, or return data without raising the flag.
- **The read register.** A design that reloads on writes or idle cycles would show a changing rdata where the value should hold.

// File: rtl/bytelane_mem_pkg.sv
package bytelane_mem_pkg;
  localparam int unsigned DEF_ADDR_W  = 16;
  localparam int unsigned DEF_CELL_AW = 6;
  localparam int unsigned DEF_BANK_AW = 3;
  localparam int unsigned DEF_LANE_W  = 8;
  localparam int unsigned LANES       = 2;

  typedef logic [LANES-1:0] lane_mask_t;

  localparam lane_mask_t LANE_NONE = 2'b00;
  localparam lane_mask_t LANE_LO   = 2'b01;
  localparam lane_mask_t LANE_HI   = 2'b10;
  localparam lane_mask_t LANE_BOTH = 2'b11;
endpackage

// File: rtl/mem_cell_1b.sv
module mem_cell_1b #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (cs && we) bits[addr] <= din;
  end

  assign dout = bits[addr];
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int unsigned BANK_AW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [BANK_AW-1:0]     bank_idx,
  output logic [(1<<BANK_AW)-1:0] bank_sel
);
  localparam int unsigned NBANK = 1 << BANK_AW;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign bank_sel[b] = en && (bank_idx == BANK_AW'(b));
  end

  p_bank_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));
  p_bank_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (bank_sel == '0));
endmodule

// File: rtl/lane_select.sv
module lane_select
  import bytelane_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       half,
  input  logic       lane_bit,
  output lane_mask_t lane_en,
  output logic       misalign
);
  assign misalign = half && lane_bit;

  always_comb begin
    if (!en || misalign)  lane_en = LANE_NONE;
    else if (half)        lane_en = LANE_BOTH;
    else if (lane_bit)    lane_en = LANE_HI;
    else                  lane_en = LANE_LO;
  end

  p_misalign_no_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (lane_en == LANE_NONE));
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !half) |-> ($countones(lane_en) == 1));
endmodule

// File: rtl/read_steer.sv
module read_steer
  import bytelane_mem_pkg::*;
#(
  parameter int unsigned NBANK  = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic [NBANK*LANES*LANE_W-1:0] bank_words,
  input  logic [NBANK-1:0]              bank_sel,
  input  lane_mask_t                    lane_en,
  output logic [LANES*LANE_W-1:0]       rd_value
);
  localparam int unsigned WW = LANES * LANE_W;

  logic [WW-1:0] picked [NBANK+1];

  assign picked[0] = '0;
  for (genvar b = 0; b < NBANK; b++) begin : g_or
    assign picked[b+1] = picked[b] |
      (bank_sel[b] ? bank_words[b*WW +: WW] : '0);
  end

  always_comb begin
    unique case (lane_en)
      LANE_BOTH: rd_value = picked[NBANK];
      LANE_LO:   rd_value = {{LANE_W{1'b0}}, picked[NBANK][LANE_W-1:0]};
      LANE_HI:   rd_value = {{LANE_W{1'b0}}, picked[NBANK][WW-1:LANE_W]};
      default:   rd_value = '0;
    endcase
  end
endmodule

// File: rtl/bytelane_mem.sv
module bytelane_mem
  import bytelane_mem_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned CELL_AW = DEF_CELL_AW,
  parameter int unsigned BANK_AW = DEF_BANK_AW,
  parameter int unsigned LANE_W  = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_en,
  input  logic                    req_wr,
  input  logic                    req_half,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    align_err
);
  localparam int unsigned WW     = LANES * LANE_W;
  localparam int unsigned NBANK  = 1 << BANK_AW;
  localparam int unsigned LOC_AW = 1 + CELL_AW + BANK_AW;

  function automatic logic addr_in_range(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LOC_AW] == '0;
  endfunction

  function automatic logic [CELL_AW-1:0] addr_row(input logic [ADDR_W-1:0] a);
    return a[CELL_AW:1];
  endfunction

  function automatic logic [BANK_AW-1:0] addr_bank(input logic [ADDR_W-1:0] a);
    return a[LOC_AW-1:CELL_AW+1];
  endfunction

  // Decoded request events, named for the assertions
  logic in_range, live, rd_fire, wr_fire, misalign;
  logic [NBANK-1:0] bank_sel;
  lane_mask_t       lane_en;
  logic [WW-1:0]    wr_bus, rd_value;
  logic [NBANK*WW-1:0] bank_words;

  assign in_range = addr_in_range(req_addr);
  assign live     = req_en && in_range;
  assign rd_fire  = req_en && !req_wr;
  assign wr_fire  = req_en && req_wr;
  assign wr_bus   = req_half ? wdata : {LANES{wdata[LANE_W-1:0]}};

  bank_decoder #(.BANK_AW(BANK_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(live),
    .bank_idx(addr_bank(req_addr)), .bank_sel(bank_sel)
  );

  lane_select u_lane (
    .clk(clk), .rst_n(rst_n), .en(live), .half(req_half),
    .lane_bit(req_addr[0]), .lane_en(lane_en), .misalign(misalign)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < WW; c++) begin : g_cell
      logic cell_cs;
      assign cell_cs = bank_sel[b] && lane_en[c / LANE_W];
      mem_cell_1b #(.AW(CELL_AW)) u_cell (
        .clk(clk), .cs(cell_cs), .we(wr_fire),
        .addr(addr_row(req_addr)), .din(wr_bus[c]),
        .dout(bank_words[b*WW + c])
      );
    end
  end

  read_steer #(.NBANK(NBANK), .LANE_W(LANE_W)) u_steer (
    .bank_words(bank_words), .bank_sel(bank_sel),
    .lane_en(lane_en), .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      align_err <= 1'b0;
    end else begin
      align_err <= req_en && req_half && req_addr[0];
      if (rd_fire) rdata <= rd_value;
    end
  end

  p_oob_no_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !in_range) |-> (bank_sel == '0));
  p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !in_range) |=> (rdata == '0));
  p_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_half && req_addr[0]) |=> align_err);
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_en && req_half && req_addr[0]) |=> !align_err);
  p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !req_half) |=> (rdata[WW-1:LANE_W] == '0));
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata));
endmodule

// File: tb/bytelane_mem_tb.sv
module bytelane_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_en = 1'b0, req_wr = 1'b0, req_half = 1'b0;
  logic [15:0] req_addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic        align_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_mem u_dut (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
    .req_half(req_half), .req_addr(req_addr), .wdata(wdata),
    .rdata(rdata), .align_err(align_err)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 16'h5A3C);
  endfunction

  function automatic bit in_map(input logic [15:0] a);
    return a < 16'h0400;
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a, input bit h);
    if (!in_map(a) || (h && a[0])) return 16'h0000;
    if (h) return {model[a + 16'd1], model[a]};
    return {8'h00, model[a]};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic op(input bit en, input bit wr, input bit h,
                    input logic [15:0] a, input logic [15:0] d);
    req_en = en; req_wr = wr; req_half = h; req_addr = a; wdata = d;
    @(negedge clk);
    if (en && wr && in_map(a) && !(h && a[0])) begin
      if (h) begin model[a] = d[7:0]; model[a + 16'd1] = d[15:8]; end
      else model[a] = d[7:0];
    end
    req_en = 0; req_wr = 0;
  endtask

  task automatic rd(input string tag, input bit h, input logic [15:0] a);
    op(1, 0, h, a, 16'h0);
    check(tag, rdata, exp_read(a, h));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset rdata", rdata, 16'h0);
    check("R9 reset align_err", {15'h0, align_err}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R4: fill every halfword, sweep back
    for (int a = 0; a < NBYTES; a += 2) op(1, 1, 1, 16'(a), pat(a));
    for (int a = 0; a < NBYTES; a += 2) rd("R1 halfword sweep", 1, 16'(a));
    for (int a = 0; a < NBYTES; a += 37) rd("R3 byte sweep", 0, 16'(a));

    // R2: byte write keeps its partner
    op(1, 1, 0, 16'h0101, 16'hFFA5);
    rd("R2 odd byte", 0, 16'h0101);
    rd("R2 partner kept", 0, 16'h0100);
    rd("R4 halfword after byte", 1, 16'h0100);
    op(1, 1, 0, 16'h03FE, 16'h0077);
    rd("R2 top even byte", 0, 16'h03FE);
    rd("R2 top partner", 0, 16'h03FF);

    // R5: misaligned halfword
    op(1, 1, 1, 16'h0203, 16'hDEAD);
    check("R5 err after write", {15'h0, align_err}, 16'h1);
    rd("R5 no write lo", 0, 16'h0203);
    check("R9 err cleared", {15'h0, align_err}, 16'h0);
    rd("R5 no write hi", 0, 16'h0204);
    rd("R5 misaligned read zero", 1, 16'h0003);
    check("R5 err after read", {15'h0, align_err}, 16'h1);

    // R6: out-of-range accesses alias nothing
    op(1, 1, 1, 16'h0410, 16'hBEEF);
    op(1, 1, 0, 16'h8011, 16'h00CC);
    rd("R6 alias 0x010", 1, 16'h0010);
    rd("R6 oob read zero", 1, 16'h0410);
    rd("R6 oob byte zero", 0, 16'hFC00);

    // R7/R8: hold and gated writes
    rd("R7 load", 1, 16'h0020);
    op(1, 1, 1, 16'h0022, 16'h1357);
    check("R7 hold over write", rdata, exp_read(16'h0020, 1));
    op(0, 0, 1, 16'h0040, 16'h0);
    check("R7 hold idle", rdata, exp_read(16'h0020, 1));
    req_en = 0; req_wr = 1; req_half = 1; req_addr = 16'h0030; wdata = 16'h9999;
    @(negedge clk);
    req_wr = 0;
    rd("R8 no write without enable", 1, 16'h0030);
    check("R8 model unchanged", exp_read(16'h0030, 1), pat(16'h30));

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      bit h, w;
      int sel = $urandom_range(0, 99);
      a = (sel < 8) ? 16'($urandom) : 16'($urandom_range(0, NBYTES-1));
      h = $urandom_range(0, 1);
      if (h && sel >= 8 && sel < 90) a[0] = 1'b0;
      w = $urandom_range(0, 2) == 0;
      if (w) op(1, 1, h, a, 16'($urandom));
      else if (h) rd("R4 random halfword", 1, a);
      else rd("R3 random byte", 0, a);
    end
    for (int a = 0; a < NBYTES; a += 2) rd("R1 final sweep", 1, 16'(a));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule